// File: doc/BRIEF.md
# Segment Base Register Unit

This unit keeps the hidden base addresses of the two general-purpose data segments, FS and GS, together with a second GS base that privileged code swaps in on entry to the kernel. Software reaches all three bases through a model-specific-register port that is addressed by index and carries 64-bit data as two 32-bit halves. When a selector is loaded into FS or GS, a descriptor-load port hands over the fetched 64-bit code/data descriptor word. The unit then puts together the 32-bit base held in that descriptor and places it in the low half of the target register. The high half stays as it was.

A swap command exchanges the active GS base with the kernel GS base in a single clock. It is honoured only when the current privilege level is 0 and the core runs in 64-bit mode. Otherwise it is refused and a fault is flagged. The unit drives the FS and GS bases used for effective-address formation. In 64-bit mode these bases are full width. In compatibility mode the upper 32 bits are forced to zero.

Top module: `segbase_unit`

## Requirements
- R1: After reset the FS, GS and kernel GS bases all read as zero, both effective bases are zero and the fault output is low.
- R2: An MSR write to index 0xC0000100 (FS), 0xC0000101 (GS) or 0xC0000102 (kernel GS) loads {high half, low half} into that base at the next clock edge.
- R3: During an MSR read to one of the three indices, the read data shows that base's stored 64-bit value in the same cycle. When no read is requested, the read data is zero.
- R4: An MSR read or write to any other index leaves all three bases unchanged. Such a read returns zero in the same cycle. The fault output is high for the one cycle after each cycle that carries such an access.
- R5: A descriptor load targets FS when the segment select is 0 and GS when it is 1. It writes base bits 15:0 from descriptor bits 31:16, bits 23:16 from descriptor bits 39:32 and bits 31:24 from descriptor bits 63:56. Base bits 63:32 keep their previous value.
- R6: With the mode flag at 1 (64-bit mode) each effective base equals the full stored base. With the flag at 0 (compatibility mode) its bits 63:32 are zero and bits 31:0 equal the stored base.
- R7: A swap request with privilege level 0 and the mode flag at 1 exchanges the GS base and the kernel GS base at the next clock edge.
- R8: A swap request at a nonzero privilege level, or with the mode flag at 0, leaves both GS bases unchanged and drives the fault output high for the following cycle.
- R9: Updates that arrive in the same cycle are applied in a fixed order: first the swap, then the descriptor load, and last the MSR write. Where they touch the same register, the later update wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msr_rd_en | input | 1 | MSR read request |
| msr_wr_en | input | 1 | MSR write request |
| msr_index | input | 32 | MSR index for read and write |
| msr_wdata_lo | input | 32 | Low half of the write data |
| msr_wdata_hi | input | 32 | High half of the write data |
| msr_rdata | output | 64 | Read data, combinational |
| desc_ld_en | input | 1 | Descriptor load strobe |
| desc_ld_gs | input | 1 | Descriptor load target: 0 selects FS, 1 selects GS |
| desc_word | input | 64 | Descriptor word that accompanies the selector |
| swap_req | input | 1 | Request to exchange the GS and kernel GS bases |
| cpl | input | 2 | Current privilege level |
| mode64 | input | 1 | 1 for 64-bit mode, 0 for compatibility mode |
| fault | output | 1 | One-cycle fault pulse |
| fs_base_eff | output | 64 | FS base for effective addresses |
| gs_base_eff | output | 64 | GS base for effective addresses |

## Verification
A permitted swap and an MSR write or descriptor load that lands on the GS or kernel GS base can fall in the same clock. Directed cycles provoke this by raising a ring-0 swap together with a write to the GS index, and again together with a write to the kernel GS index. The bench judges the result by reading both registers back and comparing them with values that follow from applying the swap first. A random phase then keeps producing such collisions, including descriptor loads and refused swaps, and a behavioural model that applies the same order is compared with the outputs on every clock.

// File: rtl/segbase_pkg.sv
package segbase_pkg;

   localparam int NUM_BASES = 3;
   localparam int DESC_W    = 64;
   localparam int DBASE_W   = 32;

   typedef enum logic [1:0] {
      SEG_FS  = 2'd0,
      SEG_GS  = 2'd1,
      SEG_KGS = 2'd2
   } seg_id_e;

   // Gather the 32-bit base scattered across a code/data descriptor
   function automatic logic [DBASE_W-1:0] desc_base(input logic [DESC_W-1:0] d);
      return {d[63:56], d[39:32], d[31:16]};
   endfunction

endpackage

// File: rtl/segbase_msr_decode.sv
module segbase_msr_decode #(
   parameter int              IDX_W   = 32,
   parameter logic [IDX_W-1:0] FS_IDX  = 'hC000_0100,
   parameter logic [IDX_W-1:0] GS_IDX  = 'hC000_0101,
   parameter logic [IDX_W-1:0] KGS_IDX = 'hC000_0102
) (
   input  logic [IDX_W-1:0]                   index,
   output logic [segbase_pkg::NUM_BASES-1:0]  hit_oh,
   output logic                               hit
);
   import segbase_pkg::*;

   localparam logic [IDX_W-1:0] IDX_TABLE [NUM_BASES] = '{FS_IDX, GS_IDX, KGS_IDX};

   for (genvar i = 0; i < NUM_BASES; i++) begin : g_cmp
      assign hit_oh[i] = (index == IDX_TABLE[i]);
   end

   assign hit = |hit_oh;

endmodule

// File: rtl/segbase_eff.sv
module segbase_eff #(
   parameter int BASE_W = 64,
   parameter int LOW_W  = 32
) (
   input  logic [BASE_W-1:0] base_in,
   input  logic              mode64,
   output logic [BASE_W-1:0] base_out
);
   if (BASE_W > LOW_W) begin : g_trunc
      assign base_out = mode64 ? base_in
                               : {{(BASE_W-LOW_W){1'b0}}, base_in[LOW_W-1:0]};
   end else begin : g_pass
      assign base_out = base_in;
   end

endmodule

// File: rtl/segbase_bank.sv
module segbase_bank #(
   parameter int BASE_W = 64,
   parameter int LOW_W  = 32
) (
   input  logic                                           clk,
   input  logic                                           rst_n,
   input  logic [segbase_pkg::NUM_BASES-1:0]              wr_oh,
   input  logic [BASE_W-1:0]                              wr_data,
   input  logic                                           ld_en,
   input  logic                                           ld_gs,
   input  logic [LOW_W-1:0]                               ld_low,
   input  logic                                           swap_go,
   output logic [segbase_pkg::NUM_BASES-1:0][BASE_W-1:0]  base_q
);
   import segbase_pkg::*;

   logic [NUM_BASES-1:0][BASE_W-1:0] base_nxt;

   // Ordered merge: swap, then descriptor load, then MSR write
   always_comb begin
      base_nxt = base_q;
      if (swap_go) begin
         base_nxt[SEG_GS]  = base_q[SEG_KGS];
         base_nxt[SEG_KGS] = base_q[SEG_GS];
      end
      if (ld_en) begin
         if (ld_gs) base_nxt[SEG_GS][LOW_W-1:0] = ld_low;
         else       base_nxt[SEG_FS][LOW_W-1:0] = ld_low;
      end
      for (int i = 0; i < NUM_BASES; i++) begin
         if (wr_oh[i]) base_nxt[i] = wr_data;
      end
   end

   for (genvar i = 0; i < NUM_BASES; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) base_q[i] <= '0;
         else        base_q[i] <= base_nxt[i];
      end
   end

   // R2
   fs_msr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_oh[SEG_FS] |=> base_q[SEG_FS] == $past(wr_data));

   // R5
   ld_upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_en && !ld_gs && !wr_oh[SEG_FS])
      |=> base_q[SEG_FS][BASE_W-1:LOW_W] == $past(base_q[SEG_FS][BASE_W-1:LOW_W]));

   // R7
   swap_exchange_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (swap_go && !ld_en && wr_oh[SEG_GS] == 1'b0 && wr_oh[SEG_KGS] == 1'b0)
      |=> (base_q[SEG_GS] == $past(base_q[SEG_KGS]))
          && (base_q[SEG_KGS] == $past(base_q[SEG_GS])));

   // R9
   swap_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (swap_go && wr_oh[SEG_GS] && !wr_oh[SEG_KGS])
      |=> (base_q[SEG_GS] == $past(wr_data))
          && (base_q[SEG_KGS] == $past(base_q[SEG_GS])));

endmodule

// File: rtl/segbase_unit.sv
module segbase_unit #(
   parameter int               BASE_W  = 64,
   parameter int               LOW_W   = 32,
   parameter int               IDX_W   = 32,
   parameter logic [IDX_W-1:0] FS_IDX  = 'hC000_0100,
   parameter logic [IDX_W-1:0] GS_IDX  = 'hC000_0101,
   parameter logic [IDX_W-1:0] KGS_IDX = 'hC000_0102
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      msr_rd_en,
   input  logic                      msr_wr_en,
   input  logic [IDX_W-1:0]          msr_index,
   input  logic [LOW_W-1:0]          msr_wdata_lo,
   input  logic [BASE_W-LOW_W-1:0]   msr_wdata_hi,
   output logic [BASE_W-1:0]         msr_rdata,
   input  logic                      desc_ld_en,
   input  logic                      desc_ld_gs,
   input  logic [63:0]               desc_word,
   input  logic                      swap_req,
   input  logic [1:0]                cpl,
   input  logic                      mode64,
   output logic                      fault,
   output logic [BASE_W-1:0]         fs_base_eff,
   output logic [BASE_W-1:0]         gs_base_eff
);
   import segbase_pkg::*;

   localparam int NUM_EFF = 2;

   if (LOW_W != DBASE_W || BASE_W <= LOW_W) begin : g_bad_width
      $error("segbase_unit: LOW_W must equal the descriptor base width and BASE_W must exceed it");
   end
   if (FS_IDX == GS_IDX || GS_IDX == KGS_IDX || FS_IDX == KGS_IDX) begin : g_bad_index
      $error("segbase_unit: register indices must be distinct");
   end

   logic [NUM_BASES-1:0]             hit_oh;
   logic                             idx_hit;
   logic [NUM_BASES-1:0][BASE_W-1:0] base_q;
   logic                             swap_allowed;
   logic                             swap_go;
   logic                             bad_access;
   logic                             fault_q;
   logic [NUM_EFF-1:0][BASE_W-1:0]   eff_base;

   segbase_msr_decode #(
      .IDX_W  (IDX_W),
      .FS_IDX (FS_IDX),
      .GS_IDX (GS_IDX),
      .KGS_IDX(KGS_IDX)
   ) u_dec (
      .index (msr_index),
      .hit_oh(hit_oh),
      .hit   (idx_hit)
   );

   assign swap_allowed = (cpl == 2'd0) && mode64;
   assign swap_go      = swap_req && swap_allowed;
   assign bad_access   = (msr_rd_en || msr_wr_en) && !idx_hit;

   segbase_bank #(
      .BASE_W(BASE_W),
      .LOW_W (LOW_W)
   ) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_oh  (hit_oh & {NUM_BASES{msr_wr_en}}),
      .wr_data({msr_wdata_hi, msr_wdata_lo}),
      .ld_en  (desc_ld_en),
      .ld_gs  (desc_ld_gs),
      .ld_low (desc_base(desc_word)),
      .swap_go(swap_go),
      .base_q (base_q)
   );

   always_comb begin
      msr_rdata = '0;
      for (int i = 0; i < NUM_BASES; i++) begin
         if (msr_rd_en && hit_oh[i]) msr_rdata = base_q[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fault_q <= 1'b0;
      else        fault_q <= bad_access || (swap_req && !swap_allowed);
   end
   assign fault = fault_q;

   for (genvar s = 0; s < NUM_EFF; s++) begin : g_eff
      segbase_eff #(
         .BASE_W(BASE_W),
         .LOW_W (LOW_W)
      ) u_eff (
         .base_in (base_q[s]),
         .mode64  (mode64),
         .base_out(eff_base[s])
      );
   end

   assign fs_base_eff = eff_base[SEG_FS];
   assign gs_base_eff = eff_base[SEG_GS];

   // R4
   bad_index_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bad_access |=> fault);

   // R4
   bad_index_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (msr_wr_en && !idx_hit && !desc_ld_en && !swap_req) |=> $stable(base_q));

   // R8
   swap_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (swap_req && !swap_allowed && !msr_wr_en && !desc_ld_en)
      |=> fault && $stable(base_q[SEG_GS]) && $stable(base_q[SEG_KGS]));

   // R6
   compat_trunc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mode64 |-> (fs_base_eff[BASE_W-1:LOW_W] == '0) && (gs_base_eff[BASE_W-1:LOW_W] == '0));

endmodule

// File: tb/sim_segbase_unit.sv
`timescale 1ns/1ps
module sim_segbase_unit;

   localparam logic [31:0] I_FS  = 32'hC000_0100;
   localparam logic [31:0] I_GS  = 32'hC000_0101;
   localparam logic [31:0] I_KGS = 32'hC000_0102;
   localparam logic [31:0] I_BAD = 32'hC000_0103;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        msr_rd_en = 1'b0, msr_wr_en = 1'b0;
   logic [31:0] msr_index = '0, msr_wdata_lo = '0, msr_wdata_hi = '0;
   logic [63:0] msr_rdata;
   logic        desc_ld_en = 1'b0, desc_ld_gs = 1'b0;
   logic [63:0] desc_word = '0;
   logic        swap_req = 1'b0;
   logic [1:0]  cpl = 2'd0;
   logic        mode64 = 1'b1;
   logic        fault;
   logic [63:0] fs_base_eff, gs_base_eff;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   bit cmp_on = 1'b0;

   segbase_unit u0 (
      .clk(clk), .rst_n(rst_n),
      .msr_rd_en(msr_rd_en), .msr_wr_en(msr_wr_en), .msr_index(msr_index),
      .msr_wdata_lo(msr_wdata_lo), .msr_wdata_hi(msr_wdata_hi), .msr_rdata(msr_rdata),
      .desc_ld_en(desc_ld_en), .desc_ld_gs(desc_ld_gs), .desc_word(desc_word),
      .swap_req(swap_req), .cpl(cpl), .mode64(mode64), .fault(fault),
      .fs_base_eff(fs_base_eff), .gs_base_eff(gs_base_eff)
   );

   always #2 clk = ~clk;

   // Behavioural reference state
   logic [63:0] m_fs = '0, m_gs = '0, m_kgs = '0;
   logic        m_fault = 1'b0;

   function automatic int which(input logic [31:0] idx);
      if (idx == I_FS)  return 0;
      if (idx == I_GS)  return 1;
      if (idx == I_KGS) return 2;
      return 3;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_fs = '0; m_gs = '0; m_kgs = '0; m_fault = 1'b0;
      end else begin
         logic [63:0] t;
         logic [31:0] b;
         int w;
         w = which(msr_index);
         m_fault = ((msr_rd_en || msr_wr_en) && w == 3) ||
                   (swap_req && !(cpl == 2'd0 && mode64));
         if (swap_req && cpl == 2'd0 && mode64) begin
            t = m_gs; m_gs = m_kgs; m_kgs = t;
         end
         if (desc_ld_en) begin
            b = {desc_word[63:56], desc_word[39:32], desc_word[31:16]};
            if (desc_ld_gs) m_gs[31:0] = b;
            else            m_fs[31:0] = b;
         end
         if (msr_wr_en) begin
            case (w)
               0: m_fs  = {msr_wdata_hi, msr_wdata_lo};
               1: m_gs  = {msr_wdata_hi, msr_wdata_lo};
               2: m_kgs = {msr_wdata_hi, msr_wdata_lo};
               default: ;
            endcase
         end
      end
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Per-cycle comparison against the model, sampled between edges
   always @(negedge clk) begin
      #1;
      if (cmp_on) begin
         logic [63:0] er;
         case (which(msr_index))
            0: er = m_fs;
            1: er = m_gs;
            2: er = m_kgs;
            default: er = '0;
         endcase
         if (!msr_rd_en) er = '0;
         chk("R3 rdata vs model", msr_rdata, er);
         chk("R4 fault vs model", {63'd0, fault}, {63'd0, m_fault});
         chk("R6 fs_base_eff vs model", fs_base_eff, mode64 ? m_fs : {32'd0, m_fs[31:0]});
         chk("R6 gs_base_eff vs model", gs_base_eff, mode64 ? m_gs : {32'd0, m_gs[31:0]});
      end
   end

   task automatic drive(input logic rd, input logic wr, input logic [31:0] idx,
                        input logic [63:0] data, input logic ld, input logic ldgs,
                        input logic [63:0] desc, input logic sw, input logic [1:0] pl,
                        input logic m64);
      @(negedge clk);
      msr_rd_en = rd; msr_wr_en = wr; msr_index = idx;
      msr_wdata_hi = data[63:32]; msr_wdata_lo = data[31:0];
      desc_ld_en = ld; desc_ld_gs = ldgs; desc_word = desc;
      swap_req = sw; cpl = pl; mode64 = m64;
   endtask

   task automatic wr_msr(input logic [31:0] idx, input logic [63:0] data);
      drive(1'b0, 1'b1, idx, data, 1'b0, 1'b0, '0, 1'b0, 2'd0, 1'b1);
   endtask

   task automatic rd_chk(input logic [31:0] idx, input logic [63:0] exp, input string tag);
      drive(1'b1, 1'b0, idx, '0, 1'b0, 1'b0, '0, 1'b0, 2'd0, 1'b1);
      #1;
      chk(tag, msr_rdata, exp);
   endtask

   task automatic idle_fault_chk(input logic exp, input string tag);
      drive(1'b0, 1'b0, I_FS, '0, 1'b0, 1'b0, '0, 1'b0, 2'd0, 1'b1);
      #1;
      chk(tag, {63'd0, fault}, {63'd0, exp});
   endtask

   initial begin
      #(4 * 100000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      #1;
      chk("R1 fs_base_eff in reset", fs_base_eff, '0);
      chk("R1 fault in reset", {63'd0, fault}, '0);
      rst_n = 1'b1;
      cmp_on = 1'b1;

      rd_chk(I_FS,  '0, "R1 FS after reset");
      rd_chk(I_GS,  '0, "R1 GS after reset");
      rd_chk(I_KGS, '0, "R1 KGS after reset");

      wr_msr(I_FS,  64'h1111_2222_3333_4444);
      wr_msr(I_GS,  64'hAAAA_BBBB_CCCC_DDDD);
      wr_msr(I_KGS, 64'h5555_6666_7777_8888);
      rd_chk(I_FS,  64'h1111_2222_3333_4444, "R2 FS write");
      rd_chk(I_GS,  64'hAAAA_BBBB_CCCC_DDDD, "R2 GS write");
      rd_chk(I_KGS, 64'h5555_6666_7777_8888, "R2 KGS write");
      drive(1'b0, 1'b0, I_FS, '0, 1'b0, 1'b0, '0, 1'b0, 2'd0, 1'b1);
      #1;
      chk("R3 rdata idle", msr_rdata, '0);

      // Descriptor base 0x12345678 spread across its three fields
      drive(1'b0, 1'b0, I_FS, '0, 1'b1, 1'b0, 64'h12CF_9A34_5678_FFFF, 1'b0, 2'd0, 1'b1);
      rd_chk(I_FS, 64'h1111_2222_1234_5678, "R5 FS descriptor load");
      drive(1'b0, 1'b0, I_FS, '0, 1'b1, 1'b1, 64'hFE00_00DC_BA98_0000, 1'b0, 2'd0, 1'b1);
      rd_chk(I_GS, 64'hAAAA_BBBB_FEDC_BA98, "R5 GS descriptor load");

      drive(1'b0, 1'b0, I_FS, '0, 1'b0, 1'b0, '0, 1'b0, 2'd0, 1'b0);
      #1;
      chk("R6 FS compat base", fs_base_eff, 64'h0000_0000_1234_5678);
      chk("R6 GS compat base", gs_base_eff, 64'h0000_0000_FEDC_BA98);
      drive(1'b0, 1'b0, I_FS, '0, 1'b0, 1'b0, '0, 1'b0, 2'd0, 1'b1);
      #1;
      chk("R6 FS 64-bit base", fs_base_eff, 64'h1111_2222_1234_5678);

      drive(1'b0, 1'b0, I_FS, '0, 1'b0, 1'b0, '0, 1'b1, 2'd0, 1'b1);
      rd_chk(I_GS,  64'h5555_6666_7777_8888, "R7 GS after swap");
      rd_chk(I_KGS, 64'hAAAA_BBBB_FEDC_BA98, "R7 KGS after swap");

      drive(1'b0, 1'b0, I_FS, '0, 1'b0, 1'b0, '0, 1'b1, 2'd3, 1'b1);
      idle_fault_chk(1'b1, "R8 fault after ring-3 swap");
      idle_fault_chk(1'b0, "R8 fault is one cycle");
      drive(1'b0, 1'b0, I_FS, '0, 1'b0, 1'b0, '0, 1'b1, 2'd0, 1'b0);
      idle_fault_chk(1'b1, "R8 fault after compat swap");
      rd_chk(I_GS, 64'h5555_6666_7777_8888, "R8 GS kept after refused swaps");

      drive(1'b1, 1'b0, I_BAD, '0, 1'b0, 1'b0, '0, 1'b0, 2'd0, 1'b1);
      #1;
      chk("R4 unknown index reads zero", msr_rdata, '0);
      idle_fault_chk(1'b1, "R4 fault after unknown read");
      wr_msr(I_BAD, 64'hFFFF_FFFF_FFFF_FFFF);
      idle_fault_chk(1'b1, "R4 fault after unknown write");
      rd_chk(I_FS, 64'h1111_2222_1234_5678, "R4 FS kept after unknown write");

      // Swap with GS write in the same cycle: swap first, write second
      drive(1'b0, 1'b1, I_GS, 64'hDEAD_BEEF_0000_0001, 1'b0, 1'b0, '0, 1'b1, 2'd0, 1'b1);
      rd_chk(I_GS,  64'hDEAD_BEEF_0000_0001, "R9 GS write after swap");
      rd_chk(I_KGS, 64'h5555_6666_7777_8888, "R9 KGS holds old GS");
      drive(1'b0, 1'b1, I_KGS, 64'h0123_4567_89AB_CDEF, 1'b0, 1'b0, '0, 1'b1, 2'd0, 1'b1);
      rd_chk(I_GS,  64'h5555_6666_7777_8888, "R9 GS from KGS");
      rd_chk(I_KGS, 64'h0123_4567_89AB_CDEF, "R9 KGS write after swap");
      // Swap plus GS descriptor load: load lands on the swapped-in value
      drive(1'b0, 1'b0, I_FS, '0, 1'b1, 1'b1, 64'h4400_0033_2211_0000, 1'b1, 2'd0, 1'b1);
      rd_chk(I_GS,  64'h0123_4567_4433_2211, "R9 GS load after swap");

      for (int n = 0; n < 3000; n++) begin
         logic [31:0] ix;
         int k;
         k = $urandom % 5;
         ix = (k == 0) ? I_FS : (k == 1) ? I_GS : (k == 2) ? I_KGS :
              (k == 3) ? I_BAD : $urandom;
         drive(($urandom % 2) == 0, ($urandom % 3) == 0, ix,
               {$urandom, $urandom}, ($urandom % 4) == 0, $urandom % 2,
               {$urandom, $urandom}, ($urandom % 4) == 0,
               (($urandom % 2) == 0) ? 2'd0 : 2'($urandom), ($urandom % 4) != 0);
      end
      drive(1'b0, 1'b0, I_FS, '0, 1'b0, 1'b0, '0, 1'b0, 2'd0, 1'b1);
      @(negedge clk);
      #2;
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule